// File: doc/BRIEF.md
# Programmable 3x3 Colour-Space Converter

The converter turns a stream of three-component pixels into another colour space, one pixel per clock. Each 10-bit input component first gets a signed per-channel offset added. The three corrected values are then multiplied by a programmable 3x3 matrix of signed fixed-point gains. A signed constant is added to each output row. The result is rounded and saturated back to 10 bits. Pixels enter and leave on valid-qualified streams with a fixed delay of three clocks.

The matrix, offsets and constants are written through a small register-write port into a shadow bank. The shadow bank becomes live only on a frame-start pulse, so every frame is converted with one consistent set. The enable and chroma-swap controls are sampled on the same pulse. When conversion is disabled, pixels pass through untouched with the same delay. The swap control exchanges the two chroma columns of the matrix, so that inputs in the other chroma order can be handled without reloading.

Top module: `csc_top`

## Requirements
- R1: While rst_n is low, out_valid is 0 and all three output components are 0; after reset the live configuration is all-zero words with conversion disabled and no swap.
- R2: A pixel accepted with in_valid high at a clock edge appears on the outputs with out_valid high exactly three rising edges later; a cycle without in_valid gives out_valid low three edges later, and back-to-back pixels leave back-to-back.
- R3: With conversion disabled, each output component equals the matching input component of the pixel accepted three edges earlier.
- R4: Coefficient word 4*r+c (c = 0..2) is the gain from input component c into output component r. Word 4*r+3 carries, in bits 31:16, the signed offset added to input component r, and in bits 15:0 the signed constant added to output r in whole output units. Output r is gain(r,0)*(in0+off0) + gain(r,1)*(in1+off1) + gain(r,2)*(in2+off2) + const(r).
- R5: Gains are 32-bit two's complement with 17 fractional bits, so 0x00020000 is a gain of exactly 1.0.
- R6: The full-precision sum is rounded to the nearest integer, with halves going upward, by adding 2^16 before dropping the 17 fractional bits.
- R7: The rounded value is saturated to 0 when negative and to 1023 when above 1023.
- R8: With swap active, gain columns 1 and 2 are exchanged in every row; the offsets and constants in word 4*r+3 keep their places.
- R9: Register writes land in a shadow bank only. The live words, the enable and the swap setting change only on a cycle with frame_start high, when they take the shadow words and the cfg_enable and cfg_swap inputs.
- R10: A register write in the same cycle as frame_start goes into the shadow bank only; the live bank takes the shadow contents from before that write.
- R11: Writes to word addresses 12 to 15 change no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| frame_start | input | 1 | One-cycle pulse that makes the shadow configuration live |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word index 0 to 11 of the write |
| wr_data | input | 32 | Write data |
| cfg_enable | input | 1 | Conversion enable, sampled on frame_start |
| cfg_swap | input | 1 | Chroma column swap, sampled on frame_start |
| in_valid | input | 1 | Input pixel qualifier |
| in_c0 | input | 10 | Input component 0 (luma) |
| in_c1 | input | 10 | Input component 1 (first chroma) |
| in_c2 | input | 10 | Input component 2 (second chroma) |
| out_valid | output | 1 | Output pixel qualifier |
| out_c0 | output | 10 | Output component 0 |
| out_c1 | output | 10 | Output component 1 |
| out_c2 | output | 10 | Output component 2 |

## Verification
A coefficient write and a frame-start commit can fall on the same clock edge. This is the case where the shadow and live banks could disagree about which value is current. The bench raises wr_en and frame_start together, with a gain that would visibly change the output. It then checks that the pixels of the following frame still follow the earlier shadow contents. A second frame_start must bring the newly written gain into effect.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int CSC_ROWS  = 3;
  localparam int CSC_COLS  = 3;
  localparam int CSC_WPR   = CSC_COLS + 1;
  localparam int CSC_WORDS = CSC_ROWS * CSC_WPR;
  localparam int CSC_AW    = 4;
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
#(
  parameter int WW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              wr_en,
  input  logic [CSC_AW-1:0] wr_addr,
  input  logic [WW-1:0]     wr_data,
  input  logic              cfg_enable,
  input  logic              cfg_swap,
  output logic [WW-1:0]     act_word [CSC_WORDS],
  output logic              act_en,
  output logic              act_swap
);
  logic [WW-1:0] shd_q [CSC_WORDS];
  logic [WW-1:0] shd_d [CSC_WORDS];
  logic [WW-1:0] act_d [CSC_WORDS];
  logic          en_d, swap_d;

  // next state: commit copies the shadow as it stood before this cycle's write
  always_comb begin
    for (int w = 0; w < CSC_WORDS; w++) begin
      shd_d[w] = (wr_en && (wr_addr == CSC_AW'(w))) ? wr_data : shd_q[w];
      act_d[w] = frame_start ? shd_q[w] : act_word[w];
    end
    en_d   = frame_start ? cfg_enable : act_en;
    swap_d = frame_start ? cfg_swap   : act_swap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < CSC_WORDS; w++) begin
        shd_q[w]    <= '0;
        act_word[w] <= '0;
      end
      act_en   <= 1'b0;
      act_swap <= 1'b0;
    end else begin
      for (int w = 0; w < CSC_WORDS; w++) begin
        shd_q[w]    <= shd_d[w];
        act_word[w] <= act_d[w];
      end
      act_en   <= en_d;
      act_swap <= swap_d;
    end
  end

  for (genvar g = 0; g < CSC_WORDS; g++) begin : g_chk
    assert_live_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> act_word[g] == $past(act_word[g]))
      else $error("live word changed without frame_start");
    assert_commit_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> act_word[g] == $past(shd_q[g]))
      else $error("commit did not take the prior shadow word");
    assert_no_alias_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr >= CSC_AW'(CSC_WORDS))) |=> shd_q[g] == $past(shd_q[g]))
      else $error("out-of-range write touched a shadow word");
  end

  assert_ctl_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_en == $past(cfg_enable)) && (act_swap == $past(cfg_swap)))
    else $error("controls not sampled on frame_start");
endmodule

// File: rtl/csc_offset_stage.sv
module csc_offset_stage
  import csc_pkg::*;
#(
  parameter int DW   = 10,
  parameter int OFSW = 16,
  parameter int OW   = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DW-1:0]          in_c  [CSC_COLS],
  input  logic signed [OFSW-1:0] offs  [CSC_COLS],
  output logic                   v1_q,
  output logic signed [OW-1:0]   op_q  [CSC_COLS]
);
  logic signed [OW-1:0] op_d [CSC_COLS];

  always_comb begin
    for (int k = 0; k < CSC_COLS; k++) begin
      op_d[k] = OW'($signed({1'b0, in_c[k]})) + OW'(offs[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      for (int k = 0; k < CSC_COLS; k++) op_q[k] <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < CSC_COLS; k++) op_q[k] <= op_d[k];
      end
    end
  end
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
#(
  parameter int DW   = 10,
  parameter int WW   = 32,
  parameter int OW   = 18,
  parameter int OFSW = 16,
  parameter int FRAC = 17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mul_ce,
  input  logic                   sum_ce,
  input  logic signed [OW-1:0]   op  [CSC_COLS],
  input  logic signed [WW-1:0]   cf  [CSC_COLS],
  input  logic signed [OFSW-1:0] cst,
  output logic [DW-1:0]          res_q
);
  localparam int PW = OW + WW;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

  logic signed [PW-1:0]   prod_q [CSC_COLS];
  logic signed [PW-1:0]   prod_d [CSC_COLS];
  logic signed [OFSW-1:0] cst_q;
  logic signed [SW-1:0]   sum_c, shf;
  logic [DW-1:0]          res_d;

  always_comb begin
    for (int k = 0; k < CSC_COLS; k++) prod_d[k] = PW'(op[k]) * PW'(cf[k]);
    sum_c = (SW'(cst_q) <<< FRAC) + HALF;
    for (int k = 0; k < CSC_COLS; k++) sum_c = sum_c + SW'(prod_q[k]);
    shf = sum_c >>> FRAC;
    if (shf < 0)         res_d = '0;
    else if (shf > MAXV) res_d = '1;
    else                 res_d = shf[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CSC_COLS; k++) prod_q[k] <= '0;
      cst_q <= '0;
      res_q <= '0;
    end else begin
      if (mul_ce) begin
        for (int k = 0; k < CSC_COLS; k++) prod_q[k] <= prod_d[k];
        cst_q <= cst;
      end
      if (sum_ce) res_q <= res_d;
    end
  end
endmodule

// File: rtl/csc_top.sv
module csc_top
  import csc_pkg::*;
#(
  parameter int DW   = 10,
  parameter int WW   = 32,
  parameter int OFSW = 16,
  parameter int FRAC = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              wr_en,
  input  logic [CSC_AW-1:0] wr_addr,
  input  logic [WW-1:0]     wr_data,
  input  logic              cfg_enable,
  input  logic              cfg_swap,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_c0,
  input  logic [DW-1:0]     in_c1,
  input  logic [DW-1:0]     in_c2,
  output logic              out_valid,
  output logic [DW-1:0]     out_c0,
  output logic [DW-1:0]     out_c1,
  output logic [DW-1:0]     out_c2
);
  localparam int OW  = ((DW > OFSW) ? DW : OFSW) + 2;
  localparam int PXW = CSC_COLS * DW;

  logic [WW-1:0]          act_word [CSC_WORDS];
  logic                   act_en, act_swap;
  logic [DW-1:0]          in_c [CSC_COLS];
  logic signed [OFSW-1:0] offs [CSC_ROWS];
  logic signed [OFSW-1:0] csts [CSC_ROWS];
  logic signed [OW-1:0]   op   [CSC_COLS];
  logic [DW-1:0]          res  [CSC_ROWS];
  logic                   v1, v2_q, v2_d, v3_q, v3_d;
  logic [PXW-1:0]         raw1_q, raw1_d, raw2_q, raw2_d, raw3_q, raw3_d;
  logic                   b1_q, b1_d, b2_q, b2_d, b3_q, b3_d;

  assign in_c[0] = in_c0;
  assign in_c[1] = in_c1;
  assign in_c[2] = in_c2;

  csc_coef_bank #(.WW(WW)) bank_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_enable(cfg_enable), .cfg_swap(cfg_swap),
    .act_word(act_word), .act_en(act_en), .act_swap(act_swap)
  );

  csc_offset_stage #(.DW(DW), .OFSW(OFSW), .OW(OW)) ofs_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_c(in_c),
    .offs(offs), .v1_q(v1), .op_q(op)
  );

  for (genvar r = 0; r < CSC_ROWS; r++) begin : g_row
    logic signed [WW-1:0] cf [CSC_COLS];
    assign offs[r] = act_word[CSC_WPR*r+CSC_COLS][WW-1 -: OFSW];
    assign csts[r] = act_word[CSC_WPR*r+CSC_COLS][OFSW-1:0];
    assign cf[0]   = act_word[CSC_WPR*r];
    assign cf[1]   = act_swap ? act_word[CSC_WPR*r+2] : act_word[CSC_WPR*r+1];
    assign cf[2]   = act_swap ? act_word[CSC_WPR*r+1] : act_word[CSC_WPR*r+2];

    csc_row #(.DW(DW), .WW(WW), .OW(OW), .OFSW(OFSW), .FRAC(FRAC)) row_i (
      .clk(clk), .rst_n(rst_n), .mul_ce(v1), .sum_ce(v2_q),
      .op(op), .cf(cf), .cst(csts[r]), .res_q(res[r])
    );
  end

  // bypass and valid pipeline, next state
  always_comb begin
    raw1_d = in_valid ? {in_c2, in_c1, in_c0} : raw1_q;
    b1_d   = in_valid ? !act_en : b1_q;
    raw2_d = v1 ? raw1_q : raw2_q;
    b2_d   = v1 ? b1_q : b2_q;
    raw3_d = v2_q ? raw2_q : raw3_q;
    b3_d   = v2_q ? b2_q : b3_q;
    v2_d   = v1;
    v3_d   = v2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw1_q <= '0; raw2_q <= '0; raw3_q <= '0;
      b1_q   <= 1'b0; b2_q <= 1'b0; b3_q <= 1'b0;
      v2_q   <= 1'b0; v3_q <= 1'b0;
    end else begin
      raw1_q <= raw1_d; raw2_q <= raw2_d; raw3_q <= raw3_d;
      b1_q   <= b1_d;   b2_q   <= b2_d;   b3_q   <= b3_d;
      v2_q   <= v2_d;   v3_q   <= v3_d;
    end
  end

  assign out_valid = v3_q;
  assign {out_c2, out_c1, out_c0} = b3_q ? raw3_q : {res[2], res[1], res[0]};

  assert_valid_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid)
    else $error("accepted pixel did not emerge after three edges");
  assert_idle_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid)
    else $error("spurious output pixel");
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && b2_q) |=> ({out_c2, out_c1, out_c0} == $past(raw2_q)))
    else $error("bypass pixel altered");
endmodule

// File: tb/csc_top_tb_top.sv
`timescale 1ns/1ps
module csc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, frame_start, wr_en, cfg_enable, cfg_swap, in_valid;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [9:0]  in_c0, in_c1, in_c2;
  logic        out_valid;
  logic [9:0]  out_c0, out_c1, out_c2;

  always #4 clk = ~clk;

  csc_top dut_i (.*);

  logic [31:0] sh_w [12];
  logic [31:0] act_w [12];
  logic        m_en, m_swap;
  int          vectors = 0;
  int          fails = 0;
  bit          done = 0;

  function automatic logic [9:0] model(int k, int x, int y, int z);
    longint d0, d1, d2, c0, c1, c2, cs, s, t;
    if (!m_en) return (k == 0) ? x[9:0] : (k == 1) ? y[9:0] : z[9:0];
    d0 = longint'($signed(act_w[3][31:16]));
    d1 = longint'($signed(act_w[7][31:16]));
    d2 = longint'($signed(act_w[11][31:16]));
    c0 = longint'($signed(act_w[4*k]));
    c1 = longint'($signed(act_w[4*k+1]));
    c2 = longint'($signed(act_w[4*k+2]));
    if (m_swap) begin t = c1; c1 = c2; c2 = t; end
    cs = longint'($signed(act_w[4*k+3][15:0]));
    s = c0*(x+d0) + c1*(y+d1) + c2*(z+d2) + cs*131072 + 65536;
    s = s >>> 17;
    if (s < 0) return 10'd0;
    if (s > 1023) return 10'd1023;
    return s[9:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
    if (a < 12) sh_w[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit(input bit en, input bit sw);
    @(negedge clk);
    frame_start = 1'b1; cfg_enable = en; cfg_swap = sw;
    act_w = sh_w; m_en = en; m_swap = sw;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic load(input logic [31:0] m [12]);
    for (int i = 0; i < 12; i++) wr(i, m[i]);
  endtask

  // single pixel, checking the valid timing and the values
  task automatic px(input int x, input int y, input int z, input string tag);
    logic [9:0] e0, e1, e2;
    e0 = model(0, x, y, z); e1 = model(1, x, y, z); e2 = model(2, x, y, z);
    @(negedge clk);
    in_valid = 1'b1; in_c0 = x[9:0]; in_c1 = y[9:0]; in_c2 = z[9:0];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 valid not yet", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R2 valid at third edge", {31'd0, out_valid}, 32'd1);
    chk({tag, " c0"}, {22'd0, out_c0}, {22'd0, e0});
    chk({tag, " c1"}, {22'd0, out_c1}, {22'd0, e1});
    chk({tag, " c2"}, {22'd0, out_c2}, {22'd0, e2});
  endtask

  task automatic stream(input int xs [6], input int ys [6], input int zs [6], input string tag);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk("R2 stream valid", {31'd0, out_valid}, 32'd1);
        chk({tag, " c0"}, {22'd0, out_c0}, {22'd0, model(0, xs[i-3], ys[i-3], zs[i-3])});
        chk({tag, " c1"}, {22'd0, out_c1}, {22'd0, model(1, xs[i-3], ys[i-3], zs[i-3])});
        chk({tag, " c2"}, {22'd0, out_c2}, {22'd0, model(2, xs[i-3], ys[i-3], zs[i-3])});
      end
      if (i < 6) begin
        in_valid = 1'b1; in_c0 = xs[i][9:0]; in_c1 = ys[i][9:0]; in_c2 = zs[i][9:0];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2 stream drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; frame_start = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    cfg_enable = 0; cfg_swap = 0; in_valid = 0; in_c0 = 0; in_c1 = 0; in_c2 = 0;
    for (int i = 0; i < 12; i++) begin sh_w[i] = 0; act_w[i] = 0; end
    m_en = 0; m_swap = 0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 outputs", {2'd0, out_c2, out_c1, out_c0}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_bypass;
    px(5, 6, 7, "R3 bypass after reset");
    px(1023, 0, 512, "R3 bypass extremes");
  endtask

  task automatic t_identity;
    logic [31:0] m [12];
    m = '{32'h20000, 0, 0, 0, 0, 32'h20000, 0, 0, 0, 0, 32'h20000, 0};
    load(m); commit(1, 0);
    px(100, 200, 300, "R5 unity gain");
    px(0, 1023, 512, "R5 unity gain edges");
  endtask

  task automatic t_limited;
    logic [31:0] m [12];
    int xs [6] = '{64, 940, 500, 300, 0, 1023};
    int ys [6] = '{512, 512, 300, 800, 0, 1023};
    int zs [6] = '{512, 512, 700, 200, 0, 1023};
    m = '{32'h2542A, 32'h0, 32'h395E2, 32'hFFC00000,
          32'h2542A, 32'hFFFF92D2, 32'hFFFEEF27, 32'hFE000005,
          32'h2542A, 32'h4398C, 32'h0, 32'hFE00FFFD};
    load(m); commit(1, 0);
    stream(xs, ys, zs, "R4 offset matrix const");
  endtask

  task automatic t_round;
    logic [31:0] m [12];
    m = '{32'h10000, 0, 0, 0, 0, 32'h10000, 0, 0, 0, 0, 32'h10000, 0};
    load(m); commit(1, 0);
    px(3, 5, 4, "R6 half rounds up");
    px(1, 7, 1023, "R6 half rounds up 2");
  endtask

  task automatic t_clamp;
    logic [31:0] m [12];
    m = '{32'h40000, 0, 0, 0, 0, 32'h20000, 0, 32'hFE000000,
          0, 0, 32'h20000, 32'h0000FFF0};
    load(m); commit(1, 0);
    px(1000, 100, 10, "R7 saturate high and low");
    px(200, 600, 900, "R7 in range");
  endtask

  task automatic t_swap;
    logic [31:0] m [12];
    m = '{32'h20000, 32'h08000, 32'h10000, 0,
          0, 32'h20000, 0, 32'hFE000200,
          0, 0, 32'h20000, 0};
    load(m); commit(1, 1);
    px(100, 300, 600, "R8 swapped columns");
    commit(1, 0);
    px(100, 300, 600, "R8 unswapped reference");
  endtask

  task automatic t_shadow;
    logic [31:0] m [12];
    m = '{32'h20000, 0, 0, 0, 0, 32'h20000, 0, 0, 0, 0, 32'h20000, 0};
    load(m); commit(1, 0);
    m = '{32'h10000, 0, 0, 0, 0, 32'h10000, 0, 0, 0, 0, 32'h10000, 0};
    load(m);
    @(negedge clk); cfg_enable = 1'b0; cfg_swap = 1'b1;
    px(400, 500, 600, "R9 shadow not live");
    commit(1, 0);
    px(400, 500, 600, "R9 live after frame_start");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h40000;
    frame_start = 1'b1; cfg_enable = 1'b1; cfg_swap = 1'b0;
    act_w = sh_w; m_en = 1; m_swap = 0;
    sh_w[0] = 32'h40000;
    @(negedge clk);
    wr_en = 1'b0; frame_start = 1'b0;
    px(300, 20, 30, "R10 same-cycle write deferred");
    commit(1, 0);
    px(300, 20, 30, "R10 deferred write now live");
  endtask

  task automatic t_ignored;
    wr(12, 32'hFFFFFFFF);
    wr(13, 32'h12345678);
    wr(15, 32'h80000000);
    commit(1, 0);
    px(300, 20, 30, "R11 high addresses ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_bypass;
    t_identity;
    t_limited;
    t_round;
    t_clamp;
    t_swap;
    t_shadow;
    t_same_cycle;
    t_ignored;
    commit(0, 0);
    px(77, 88, 99, "R3 bypass after disable");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule